// File: doc/BRIEF.md
# Dual-Mode Radix-4 Booth Multiplier

This block is a purely combinational parallel multiplier for two 8-bit operands. It returns the complete 16-bit product. A single mode pin selects how both operands are read: as two's complement numbers or as plain unsigned magnitudes. Both readings go through the same hardware.

Each operand is first widened by one bit. In signed mode that bit repeats the operand's top bit, and in unsigned mode it is zero. The widened multiplier is recoded into radix-4 Booth digits. Because of the widening, the datapath forms one more partial product row than an 8-bit Booth array would: five rows instead of four.

A negative digit is built as the inverted multiple, and a +1 correction is placed in that row's lowest column. Every row is sign-extended to 16 bits. The rows and the correction bits are compressed to a sum row and a carry row by 3:2 carry-save stages. A carry-lookahead adder built from 4-bit groups then produces the product.

Top module: `dual_mode_booth_mul`

## Requirements
- R1: With `sgn_mode` = 0, `product` equals the unsigned product of `mcand` and `mplier`, all 16 bits.
- R2: With `sgn_mode` = 1, `product` equals the two's complement product of `mcand` and `mplier`, read as a 16-bit two's complement value.
- R3: The mode pin changes the result only through the operand top bits. For example, 0xFF times 0xFF gives 0xFE01 with `sgn_mode` = 0 and 0x0001 with `sgn_mode` = 1. Likewise, 0x80 times 0x7F gives 0x3F80 in unsigned mode and 0xC080 in signed mode.
- R4: Each Booth digit selects at most one magnitude, either 1 or 2. A negative sign is never paired with a zero magnitude. Windows 000 and 111 give 0, windows 001 and 010 give +1, 011 gives +2, 100 gives -2, and 101 and 110 give -1.
- R5: Modulo 2^16, the sum row plus the carry row from the carry-save stages equals the sum of all partial product rows plus the correction row.
- R6: If either operand is zero, `product` is zero in both modes.
- R7: The block holds no state. `product` is valid in the same cycle its inputs change, with no clock edge involved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sgn_mode | input | 1 | 1 selects two's complement operands, 0 selects unsigned operands |
| mcand | input | 8 | Multiplicand |
| mplier | input | 8 | Multiplier, recoded into Booth digits |
| product | output | 16 | Full product |

## Verification
All results are due in the same cycle, with zero clock latency. The bench drives new operands just after a rising edge and compares `product` at the next falling edge, half a period later. One extra check changes the inputs in the middle of a cycle and samples 1 ns later, which shows that no register sits on the path. The sweep covers every operand pair in both modes against arithmetic computed in the bench. Targeted vectors name the mode-contrast, zero and Booth-window cases.

// File: rtl/dmb_pkg.sv
// Package: shared types for the dual-mode Booth multiplier.
// Assumes: a Booth digit is stored as sign plus one-hot magnitude.
package dmb_pkg;

    // One radix-4 Booth digit: neg = negative, one = |1|, two = |2|.
    typedef struct packed {
        logic neg;
        logic one;
        logic two;
    } bdigit_t;

endpackage

// File: rtl/dmb_recoder.sv
// Module: dmb_recoder
// Recodes the widened multiplier into NR radix-4 Booth digits.
// Assumes: the input already carries its extension bit; the value is
// sign-extended to an even width and an implicit zero sits below bit 0.
module dmb_recoder
    import dmb_pkg::*;
#(
    parameter int XW = 9,
    parameter int NR = 5
) (
    input  logic [XW-1:0]        mult,
    output bdigit_t [NR-1:0]     digits
);
    localparam int BW = 2 * NR;

    logic [BW:0] padded;

    // Build the padded multiplier: bit 0 is the implicit zero below the LSB.
    always_comb begin
        padded[0] = 1'b0;
        for (int k = 0; k < BW; k++) begin
            padded[k+1] = (k < XW) ? mult[k] : mult[XW-1];
        end
    end

    for (genvar i = 0; i < NR; i++) begin : g_win
        logic [2:0] win;
        assign win = padded[2*i+2 : 2*i];
        // Decode one overlapping three-bit window into sign and magnitude.
        always_comb begin
            digits[i].neg = win[2] & ~(win[1] & win[0]);
            digits[i].one = win[1] ^ win[0];
            digits[i].two = (win == 3'b011) | (win == 3'b100);
        end
    end

endmodule

// File: rtl/dmb_ppgen.sv
// Module: dmb_ppgen
// Forms one PW-bit partial product row per Booth digit, plus a correction
// row that carries the +1 for every negative digit at column 2*i.
// Assumes: the multiplicand is widened (XW bits, signed) and PW > 2*(NR-1).
module dmb_ppgen
    import dmb_pkg::*;
#(
    parameter int XW = 9,
    parameter int NR = 5,
    parameter int PW = 16
) (
    input  logic [XW-1:0]        mcand_x,
    input  bdigit_t [NR-1:0]     digits,
    output logic [NR:0][PW-1:0]  rows
);
    logic [PW-1:0] mult1;
    logic [PW-1:0] mult2;

    // Sign-extend the widened multiplicand to product width and form 2x.
    always_comb begin
        for (int k = 0; k < PW; k++) begin
            mult1[k] = (k < XW) ? mcand_x[k] : mcand_x[XW-1];
        end
        mult2 = mult1 << 1;
    end

    for (genvar i = 0; i < NR; i++) begin : g_row
        logic [PW-1:0] sel;
        // Pick the multiple, invert when negative, shift to the row weight.
        always_comb begin
            if (digits[i].two) begin
                sel = mult2;
            end else if (digits[i].one) begin
                sel = mult1;
            end else begin
                sel = '0;
            end
            if (digits[i].neg) begin
                sel = ~sel;
            end
            rows[i] = sel << (2 * i);
        end
    end

    // Gather the +1 corrections of the negative rows into one extra row.
    always_comb begin
        rows[NR] = '0;
        for (int i = 0; i < NR; i++) begin
            rows[NR][2*i] = digits[i].neg;
        end
    end

endmodule

// File: rtl/dmb_csa_reduce.sv
// Module: dmb_csa_reduce
// Compresses NIN rows to a sum row and a carry row using 3:2 carry-save
// stages; carries are shifted one column left and truncated at PW.
// Assumes: NIN >= 3; results are modulo 2^PW.
module dmb_csa_reduce #(
    parameter int NIN = 6,
    parameter int PW  = 16
) (
    input  logic [NIN-1:0][PW-1:0] rows,
    output logic [PW-1:0]          sum_row,
    output logic [PW-1:0]          carry_row
);
    localparam int NST = NIN - 1;

    logic [NST-1:0][PW-1:0] s_v;
    logic [NST-1:0][PW-1:0] c_v;

    // Seed the chain with the first two rows as a redundant pair.
    assign s_v[0] = rows[0];
    assign c_v[0] = rows[1];

    for (genvar k = 1; k < NST; k++) begin : g_stage
        logic [PW-1:0] maj;
        // Add one more row to the pair with a row of full adders.
        always_comb begin
            maj    = (s_v[k-1] & c_v[k-1]) | (s_v[k-1] & rows[k+1]) | (c_v[k-1] & rows[k+1]);
            s_v[k] = s_v[k-1] ^ c_v[k-1] ^ rows[k+1];
            c_v[k] = maj << 1;
        end
    end

    assign sum_row   = s_v[NST-1];
    assign carry_row = c_v[NST-1];

endmodule

// File: rtl/dmb_cla.sv
// Module: dmb_cla
// Carry-lookahead adder: GW-bit groups produce group generate/propagate,
// a flat lookahead unit forms every group carry-in from them.
// Assumes: PW is a multiple of GW; carry-in is zero, carry-out dropped.
module dmb_cla #(
    parameter int PW = 16,
    parameter int GW = 4
) (
    input  logic [PW-1:0] op_a,
    input  logic [PW-1:0] op_b,
    output logic [PW-1:0] sum
);
    localparam int NG = PW / GW;

    logic [PW-1:0] gen;
    logic [PW-1:0] prp;
    logic [NG-1:0] grp_g;
    logic [NG-1:0] grp_p;
    logic [NG-1:0] grp_cin;
    logic [PW-1:0] cbit;

    assign gen = op_a & op_b;
    assign prp = op_a ^ op_b;

    // Group generate and propagate for each GW-bit slice.
    always_comb begin
        for (int j = 0; j < NG; j++) begin
            grp_g[j] = 1'b0;
            grp_p[j] = 1'b1;
            for (int b = 0; b < GW; b++) begin
                grp_g[j] = gen[j*GW+b] | (prp[j*GW+b] & grp_g[j]);
                grp_p[j] = grp_p[j] & prp[j*GW+b];
            end
        end
    end

    // Lookahead unit: each group carry-in as a flat sum of products.
    always_comb begin
        logic term;
        for (int j = 0; j < NG; j++) begin
            grp_cin[j] = 1'b0;
            for (int k = 0; k < j; k++) begin
                term = grp_g[k];
                for (int m = k + 1; m < j; m++) begin
                    term = term & grp_p[m];
                end
                grp_cin[j] = grp_cin[j] | term;
            end
        end
    end

    // In-group carries from the group carry-in, then the sum bits.
    always_comb begin
        for (int j = 0; j < NG; j++) begin
            cbit[j*GW] = grp_cin[j];
            for (int b = 1; b < GW; b++) begin
                cbit[j*GW+b] = gen[j*GW+b-1] | (prp[j*GW+b-1] & cbit[j*GW+b-1]);
            end
        end
        sum = prp ^ cbit;
    end

endmodule

// File: rtl/dual_mode_booth_mul.sv
// Module: dual_mode_booth_mul (top)
// Combinational W x W multiplier for signed or unsigned operands. Both
// operands gain one extension bit (MSB copy in signed mode, zero in
// unsigned), so one radix-4 Booth datapath covers both formats.
// Assumes: product is the low 2*W bits; no clock, no state.
module dual_mode_booth_mul
    import dmb_pkg::*;
#(
    parameter int W = 8
) (
    input  logic           sgn_mode,
    input  logic [W-1:0]   mcand,
    input  logic [W-1:0]   mplier,
    output logic [2*W-1:0] product
);
    localparam int XW = W + 1;
    localparam int BW = XW + (XW % 2);
    localparam int NR = BW / 2;
    localparam int PW = 2 * W;

    logic [XW-1:0]       xa;
    logic [XW-1:0]       xb;
    bdigit_t [NR-1:0]    digs;
    logic [NR:0][PW-1:0] rows;
    logic [PW-1:0]       vs;
    logic [PW-1:0]       vc;

    // Widen both operands with the mode-dependent extension bit.
    assign xa = {sgn_mode & mcand[W-1], mcand};
    assign xb = {sgn_mode & mplier[W-1], mplier};

    dmb_recoder #(.XW(XW), .NR(NR)) u_rec (
        .mult   (xb),
        .digits (digs)
    );

    dmb_ppgen #(.XW(XW), .NR(NR), .PW(PW)) u_pp (
        .mcand_x (xa),
        .digits  (digs),
        .rows    (rows)
    );

    dmb_csa_reduce #(.NIN(NR + 1), .PW(PW)) u_csa (
        .rows      (rows),
        .sum_row   (vs),
        .carry_row (vc)
    );

    dmb_cla #(.PW(PW), .GW(4)) u_add (
        .op_a (vs),
        .op_b (vc),
        .sum  (product)
    );

endmodule

// File: rtl/dmb_checker.sv
// Module: dmb_checker
// Immediate assertions on the multiplier's ports and internal rows.
// Assumes: the block is combinational, so checks are evaluated on settle.
module dmb_checker
    import dmb_pkg::*;
#(
    parameter int W = 8
) (
    input logic                  sgn_mode,
    input logic [W-1:0]          mcand,
    input logic [W-1:0]          mplier,
    input logic [2*W-1:0]        product,
    input bdigit_t [((W+1+((W+1)%2))/2)-1:0] digits,
    input logic [((W+1+((W+1)%2))/2):0][2*W-1:0] rows,
    input logic [2*W-1:0]        sum_row,
    input logic [2*W-1:0]        carry_row
);
    localparam int NR = (W + 1 + ((W + 1) % 2)) / 2;
    localparam int PW = 2 * W;

    logic [PW-1:0]        exp_u;
    logic signed [PW-1:0] exp_s;
    logic [PW-1:0]        row_total;

    // Reference products and row total for the checks below.
    always_comb begin
        exp_u = PW'(mcand) * PW'(mplier);
        exp_s = $signed(mcand) * $signed(mplier);
        row_total = '0;
        for (int i = 0; i <= NR; i++) begin
            row_total = row_total + rows[i];
        end
    end

    // Product, zero and row-conservation checks.
    always_comb begin
        if (!sgn_mode) begin
            AST_UNSIGNED_PRODUCT: assert (product == exp_u); // R1
        end
        if (sgn_mode) begin
            AST_SIGNED_PRODUCT: assert (product == exp_s); // R2
        end
        if (mcand == '0 || mplier == '0) begin
            AST_ZERO_OPERAND: assert (product == '0); // R6
        end
        AST_CSA_CONSERVES: assert (PW'(sum_row + carry_row) == row_total); // R5
    end

    // Booth digit legality for every row.
    always_comb begin
        for (int i = 0; i < NR; i++) begin
            AST_DIGIT_ONE_MAG: assert (!(digits[i].one && digits[i].two)); // R4
            AST_DIGIT_NO_NEG_ZERO: assert (!(digits[i].neg && !digits[i].one && !digits[i].two)); // R4
        end
    end

endmodule

bind dual_mode_booth_mul dmb_checker #(.W(W)) u_chk (
    .sgn_mode  (sgn_mode),
    .mcand     (mcand),
    .mplier    (mplier),
    .product   (product),
    .digits    (digs),
    .rows      (rows),
    .sum_row   (vs),
    .carry_row (vc)
);

// File: tb/dual_mode_booth_mul_tb_top.sv
// Bench: exhaustive sweep of both modes plus targeted vectors.
// Inputs change just after a rising edge; product is sampled at the
// following falling edge (zero-latency block).
module dual_mode_booth_mul_tb_top;

    logic        clk;
    logic        rst_n;
    logic        sgn_mode;
    logic [7:0]  mcand;
    logic [7:0]  mplier;
    logic [15:0] product;

    int n_vec;
    int n_bad;
    bit done;

    dual_mode_booth_mul #(.W(8)) dut_i (
        .sgn_mode (sgn_mode),
        .mcand    (mcand),
        .mplier   (mplier),
        .product  (product)
    );

    // 200 MHz clock.
    initial clk = 1'b0;
    always #2.5 clk = ~clk;

    // Arithmetic reference computed from the requirements.
    function automatic logic [15:0] ref_prod(input logic md, input logic [7:0] a, input logic [7:0] b);
        logic signed [15:0] s;
        logic [15:0] u;
        u = 16'(a) * 16'(b);
        s = $signed(a) * $signed(b);
        return md ? 16'(s) : u;
    endfunction

    task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s mode=%0d a=%h b=%h got %h expected %h", tag, sgn_mode, mcand, mplier, got, exp);
        end
    endtask

    // Drive one vector after a rising edge, compare at the falling edge.
    task automatic apply(input string tag, input logic md, input logic [7:0] a, input logic [7:0] b);
        @(posedge clk);
        #0.5;
        sgn_mode = md;
        mcand    = a;
        mplier   = b;
        @(negedge clk);
        check(tag, product, ref_prod(md, a, b));
    endtask

    // Watchdog: a hung run counts as a failed check and still reports.
    initial begin
        for (int c = 0; c < 190000; c++) begin
            @(posedge clk);
        end
        if (!done) begin
            n_bad++;
            n_vec++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        n_vec = 0;
        n_bad = 0;
        done = 1'b0;
        rst_n = 1'b0;
        sgn_mode = 1'b0;
        mcand = 8'h00;
        mplier = 8'h00;
        repeat (4) @(posedge clk);
        rst_n = 1'b1;

        // Reset state: idle inputs give zero (R6).
        @(negedge clk);
        check("R6 reset", product, 16'h0000);

        // Mode contrast with fixed expected constants (R3).
        apply("R3", 1'b0, 8'hFF, 8'hFF);
        check("R3 const", product, 16'hFE01);
        apply("R3", 1'b1, 8'hFF, 8'hFF);
        check("R3 const", product, 16'h0001);
        apply("R3", 1'b0, 8'h80, 8'h7F);
        check("R3 const", product, 16'h3F80);
        apply("R3", 1'b1, 8'h80, 8'h7F);
        check("R3 const", product, 16'hC080);
        apply("R3", 1'b1, 8'h80, 8'h80);
        check("R3 const", product, 16'h4000);

        // Zero operand against a full-scale operand (R6).
        apply("R6", 1'b0, 8'h00, 8'hFF);
        apply("R6", 1'b1, 8'hFF, 8'h00);
        apply("R6", 1'b1, 8'h00, 8'h80);

        // Multipliers that exercise every Booth window code (R4).
        foreach (dut_i.mcand[i]) begin end
        for (int md = 0; md < 2; md++) begin
            apply("R4", md[0], 8'h93, 8'h02);
            apply("R4", md[0], 8'h93, 8'h03);
            apply("R4", md[0], 8'h93, 8'h55);
            apply("R4", md[0], 8'h93, 8'hAA);
            apply("R4", md[0], 8'h93, 8'h7F);
            apply("R4", md[0], 8'h93, 8'h9C);
        end

        // Operands that fill every partial product row (R5).
        apply("R5", 1'b1, 8'h81, 8'hAA);
        apply("R5", 1'b0, 8'hFF, 8'hAB);

        // Same-cycle response: change mid-cycle, sample 1 ns later (R7).
        @(negedge clk);
        sgn_mode = 1'b0;
        mcand    = 8'hC3;
        mplier   = 8'h5A;
        #1;
        check("R7", product, 16'hC3 * 16'h5A);

        // Exhaustive sweep: unsigned (R1) then signed (R2).
        for (int md = 0; md < 2; md++) begin
            for (int a = 0; a < 256; a++) begin
                for (int b = 0; b < 256; b++) begin
                    apply(md == 0 ? "R1" : "R2", md[0], a[7:0], b[7:0]);
                end
            end
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule